// File: doc/BRIEF.md
# Three-Phase Complementary Gate Generator

This block drives the six gates of a three-phase inverter bridge. A 16-bit triangle counter sweeps up and back down once per switching period. Each phase compares the count against its own duty word to form a high-side gate and a complementary low-side gate. A guard interval separates the two gates of a pair, and it is taken equally from both edges of every pulse, so each pulse stays centred.

Configuration arrives through a small write-only port into shadow registers. The shadow values reach the comparators only at fixed points in the period: at each period start, or at the period start and the turning point of the sweep. Each phase can exchange its two gates. Either side can be gated with a fast carrier. Pulses narrower than a programmable floor are suppressed. A one-cycle marker flags every period start.

Top module: `tri_gate_pwm`

## Requirements
- R1: While rst_n is low, and in the first cycles after it rises, every gate output is low.
- R2: With active period P ≥ 1, the count steps up 0..P-1 and then down P-1..0, so a period lasts 2P cycles. sync_pulse is high for exactly one cycle per period, in the cycle where the count is 0 on the rising leg.
- R3: For phase p with duty D and guard G, the raw high gate is on while count < D−G, taken as 0 if D ≤ G. The raw low gate is on while count ≥ D+G. The two gates of a pair are never on together.
- R4: The guard G shortens the high pulse by G counts on each side of the period start. It delays the low pulse by G counts on each side of the turning point. Pulse symmetry about those points is kept.
- R5: With ctrl bit 0 clear, shadow values are copied to the active set only on the edge that starts a period. The count at that start is 0.
- R6: With active ctrl bit 0 set, duty, guard, minimum width, exchange and carrier enables are also copied at the turning point. The period and the mode bit are copied only at the period start.
- R7: ctrl bits 3:1 are the exchange flags for phases 2:0. When a phase's flag is set, its high and low outputs are swapped.
- R8: A carrier toggles every clock and starts at 0 after reset. ctrl bit 4 ANDs every high output with it, and ctrl bit 5 does the same for every low output.
- R9: A high pulse whose half-width D−G is below the minimum width M is removed. A low pulse whose half-width P−(D+G) is below M is removed.
- R10: The write port maps address 0 to period, 1 to guard, 2 to minimum width, 3..5 to the duty of phases 0..2, and 6 to ctrl. A write to address 7 changes nothing.
- R11: While the active period is 0, all six gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the shadow registers |
| wr_addr | input | 3 | Shadow register select |
| wr_data | input | 16 | Write data |
| gate_hi | output | 3 | High-side gates, bit p for phase p |
| gate_lo | output | 3 | Low-side gates, bit p for phase p |
| sync_pulse | output | 1 | One-cycle marker at each period start |

## Verification
A wrong count or direction shifts every gate edge and the sync marker, so it shows at the ports within one half period. A wrong active register shows at the first edge that uses it. A copy at the wrong moment shows only after a shadow write that lands between two load points. For this reason the bench writes at offsets inside the period that vary from write to write. The bench compares all seven outputs every cycle with a behavioural model.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int unsigned CNT_W  = 16;
    localparam int unsigned NUM_PH = 3;
    localparam int unsigned ADDR_W = 3;

    localparam int unsigned ADR_PERIOD = 0;
    localparam int unsigned ADR_GUARD  = 1;
    localparam int unsigned ADR_MINW   = 2;
    localparam int unsigned ADR_DUTY0  = 3;
    localparam int unsigned ADR_CTRL   = ADR_DUTY0 + NUM_PH;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [CNT_W:0]    wide_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        cnt_t                          period;
        cnt_t                          guard;
        cnt_t                          minw;
        logic [NUM_PH-1:0][CNT_W-1:0]  duty;
        logic                          dbl;
        logic [NUM_PH-1:0]             xover;
        logic                          chop_hi;
        logic                          chop_lo;
    } cfg_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cnt_t period,
    output cnt_t cnt,
    output logic down,
    output logic carrier,
    output logic to_up,
    output logic to_down
);
    typedef struct packed {
        cnt_t cnt;
        logic down;
        logic carrier;
    } tb_t;

    tb_t   st_d, st_q;
    wide_t nxt_up;

    always_comb begin
        st_d         = st_q;
        st_d.carrier = ~st_q.carrier;
        nxt_up       = {1'b0, st_q.cnt} + wide_t'(1);
        to_up        = 1'b0;
        to_down      = 1'b0;
        if (!st_q.down) begin
            if (nxt_up >= {1'b0, period}) begin
                st_d.down = 1'b1;   // turning point: count holds (R2)
                to_down   = 1'b1;
            end else begin
                st_d.cnt = nxt_up[CNT_W-1:0];
            end
        end else begin
            if (st_q.cnt == '0) begin
                st_d.down = 1'b0;   // period start (R5)
                to_up     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - cnt_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign down    = st_q.down;
    assign carrier = st_q.carrier;
endmodule

// File: rtl/pwm_phase.sv
module pwm_phase
    import pwm_pkg::*;
(
    input  cnt_t cnt,
    input  cnt_t period,
    input  cnt_t duty,
    input  cnt_t guard,
    input  cnt_t minw,
    input  logic xover,
    input  logic chop_hi,
    input  logic chop_lo,
    input  logic carrier,
    output logic gate_hi,
    output logic gate_lo
);
    wide_t cnt_w, per_w, duty_w, grd_w, min_w;
    wide_t hi_w, lo_start, lo_w;
    logic  run, hi_raw, lo_raw, sw_hi, sw_lo;

    always_comb begin
        cnt_w    = {1'b0, cnt};
        per_w    = {1'b0, period};
        duty_w   = {1'b0, duty};
        grd_w    = {1'b0, guard};
        min_w    = {1'b0, minw};
        run      = (period != '0);                                  // R11
        hi_w     = (duty_w > grd_w) ? (duty_w - grd_w) : '0;        // R4
        lo_start = duty_w + grd_w;
        lo_w     = (per_w > lo_start) ? (per_w - lo_start) : '0;
        hi_raw   = run && (cnt_w < hi_w) && (hi_w >= min_w);        // R3, R9
        lo_raw   = run && (cnt_w >= lo_start) && (lo_w >= min_w);
        sw_hi    = xover ? lo_raw : hi_raw;                         // R7
        sw_lo    = xover ? hi_raw : lo_raw;
        gate_hi  = sw_hi && (!chop_hi || carrier);                  // R8
        gate_lo  = sw_lo && (!chop_lo || carrier);
    end
endmodule

// File: rtl/tri_gate_pwm.sv
module tri_gate_pwm
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NUM_PH-1:0] gate_hi,
    output logic [NUM_PH-1:0] gate_lo,
    output logic              sync_pulse
);
    typedef struct packed {
        cfg_t shadow;
        cfg_t active;
    } regs_t;

    regs_t st_d, st_q;
    cnt_t  tb_cnt;
    logic  tb_down, tb_carrier, tb_to_up, tb_to_down;
    cnt_t  act_period;

    pwm_timebase u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .period  (st_q.active.period),
        .cnt     (tb_cnt),
        .down    (tb_down),
        .carrier (tb_carrier),
        .to_up   (tb_to_up),
        .to_down (tb_to_down)
    );

    always_comb begin
        st_d = st_q;
        // R10: shadow write decode
        if (wr_en) begin
            if (wr_addr == addr_t'(ADR_PERIOD)) st_d.shadow.period = wr_data;
            if (wr_addr == addr_t'(ADR_GUARD))  st_d.shadow.guard  = wr_data;
            if (wr_addr == addr_t'(ADR_MINW))   st_d.shadow.minw   = wr_data;
            for (int p = 0; p < NUM_PH; p++) begin
                if (wr_addr == addr_t'(ADR_DUTY0 + p)) st_d.shadow.duty[p] = wr_data;
            end
            if (wr_addr == addr_t'(ADR_CTRL)) begin
                st_d.shadow.dbl     = wr_data[0];
                st_d.shadow.xover   = wr_data[NUM_PH:1];
                st_d.shadow.chop_hi = wr_data[NUM_PH+1];
                st_d.shadow.chop_lo = wr_data[NUM_PH+2];
            end
        end
        // R5: full copy at period start; R6: partial copy at turning point
        if (tb_to_up) begin
            st_d.active = st_q.shadow;
        end else if (tb_to_down && st_q.active.dbl) begin
            st_d.active.guard   = st_q.shadow.guard;
            st_d.active.minw    = st_q.shadow.minw;
            st_d.active.duty    = st_q.shadow.duty;
            st_d.active.xover   = st_q.shadow.xover;
            st_d.active.chop_hi = st_q.shadow.chop_hi;
            st_d.active.chop_lo = st_q.shadow.chop_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        for (genvar g = 0; g < NUM_PH; g++) begin : g_ph
            pwm_phase u_ph (
                .cnt     (tb_cnt),
                .period  (st_q.active.period),
                .duty    (st_q.active.duty[g]),
                .guard   (st_q.active.guard),
                .minw    (st_q.active.minw),
                .xover   (st_q.active.xover[g]),
                .chop_hi (st_q.active.chop_hi),
                .chop_lo (st_q.active.chop_lo),
                .carrier (tb_carrier),
                .gate_hi (gate_hi[g]),
                .gate_lo (gate_lo[g])
            );
        end
    endgenerate

    assign act_period = st_q.active.period;
    assign sync_pulse = !tb_down && (tb_cnt == '0);   // R2
endmodule

// File: rtl/pwm_props.sv
module pwm_props
    import pwm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_PH-1:0] gate_hi,
    input logic [NUM_PH-1:0] gate_lo,
    input logic              sync_pulse,
    input cnt_t              cnt,
    input logic              down,
    input cnt_t              period
);
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo) == '0);

    a_r2_sync_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> !sync_pulse);

    a_r2_sync_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_pulse && period > cnt_t'(1)) |=> (cnt == cnt_t'(1) && !down));

    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (period != '0) |-> (cnt < period));

    a_r11_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0) |-> (gate_hi == '0 && gate_lo == '0));
endmodule

bind tri_gate_pwm pwm_props u_props (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo),
    .sync_pulse (sync_pulse),
    .cnt        (tb_cnt),
    .down       (tb_down),
    .period     (act_period)
);

// File: tb/sim_tri_gate_pwm.sv
module sim_tri_gate_pwm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0] gate_hi, gate_lo;
    logic       sync_pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int sync_seen = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;   // 250 MHz

    tri_gate_pwm u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .sync_pulse(sync_pulse)
    );

    // behavioural reference: index 0 period, 1 guard, 2 min width, 3..5 duty, 6 ctrl
    int  sh [7];
    int  ac [7];
    int  m_cnt;
    bit  m_down;
    bit  m_car;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_down <= 0; m_car <= 0;
            for (int i = 0; i < 7; i++) begin sh[i] <= 0; ac[i] <= 0; end
        end else begin
            m_car <= !m_car;
            if (!m_down) begin
                if (m_cnt + 1 >= ac[0]) begin
                    m_down <= 1;
                    if (ac[6] % 2 == 1) begin
                        for (int i = 1; i < 6; i++) ac[i] <= sh[i];
                        ac[6] <= (sh[6] / 2) * 2 + 1;
                    end
                end else m_cnt <= m_cnt + 1;
            end else if (m_cnt == 0) begin
                m_down <= 0;
                for (int i = 0; i < 7; i++) ac[i] <= sh[i];
            end else m_cnt <= m_cnt - 1;
            if (wr_en && wr_addr < 3'd7) sh[wr_addr] <= int'(wr_data);
        end
    end

    function automatic bit bitof(int v, int b);
        return ((v >> b) & 1) == 1;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            bit [2:0] eh, el;
            for (int p = 0; p < 3; p++) begin
                int d, g, m, per, hw, ls, lw;
                bit rh, rl, xh, xl;
                d = ac[3+p]; g = ac[1]; m = ac[2]; per = ac[0];
                hw = (d > g) ? d - g : 0;
                ls = d + g;
                lw = (per > ls) ? per - ls : 0;
                rh = (per != 0) && (m_cnt < hw) && (hw >= m);
                rl = (per != 0) && (m_cnt >= ls) && (lw >= m);
                xh = bitof(ac[6], 1 + p) ? rl : rh;
                xl = bitof(ac[6], 1 + p) ? rh : rl;
                eh[p] = xh && (!bitof(ac[6], 4) || m_car);
                el[p] = xl && (!bitof(ac[6], 5) || m_car);
            end
            check({gate_hi, gate_lo} == {eh, el}, cur_req,
                  int'({gate_hi, gate_lo}), int'({eh, el}));
            check(sync_pulse == (!m_down && m_cnt == 0), "R2 sync",
                  int'(sync_pulse), int'(!m_down && m_cnt == 0));
            if (sync_pulse) sync_seen++;
        end
    end

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_up();
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        run(4);
        check(gate_hi == 3'b0 && gate_lo == 3'b0, "R1 in reset", int'({gate_hi, gate_lo}), 0);
        rst_n = 1'b1;
        run(1);
        check(gate_hi == 3'b0 && gate_lo == 3'b0, "R1 after reset", int'({gate_hi, gate_lo}), 0);

        cur_req = "R11";
        run(10);

        cur_req = "R10";
        wr(0, 20); wr(1, 2); wr(2, 0);
        wr(3, 8); wr(4, 12); wr(5, 3); wr(6, 0);
        wr(7, 16'hFFFF);
        run(100);

        cur_req = "R3";
        wr(5, 30);
        run(90);

        cur_req = "R4";
        wr(1, 5);
        run(100);

        cur_req = "R2";
        run(3);
        sync_seen = 0;
        run(400);
        check(sync_seen == 10, "R2 sync count", sync_seen, 10);

        cur_req = "R5";
        for (int k = 0; k < 8; k++) begin
            wr(3 + (k % 3), 2 + 3 * k);
            run(9 + 4 * k);
        end
        run(60);

        cur_req = "R6";
        wr(6, 1);
        run(45);
        for (int k = 0; k < 10; k++) begin
            wr(3 + (k % 3), 17 - k);
            run(5 + 3 * k);
        end
        wr(1, 1);
        run(80);

        cur_req = "R7";
        wr(6, 1 | (5 << 1));
        run(90);
        wr(6, 1 << 2);
        run(90);

        cur_req = "R8";
        wr(6, 16'h30 | 16'h4);
        run(90);
        wr(6, 16'h10);
        run(90);

        cur_req = "R9";
        wr(6, 0); wr(1, 5); wr(2, 5);
        wr(3, 6); wr(4, 15); wr(5, 10);
        run(120);
        wr(3, 0); wr(2, 1);
        run(90);

        cur_req = "R11";
        wr(0, 0);
        run(80);

        cur_req = "R1";
        @(negedge clk); rst_n = 1'b0;
        run(2);
        check(gate_hi == 3'b0 && gate_lo == 3'b0, "R1 reapplied", int'({gate_hi, gate_lo}), 0);
        rst_n = 1'b1;
        run(20);

        finish_up();
    end
endmodule